// File: doc/BRIEF.md
# Deferred-Fault Token Tracker

This block keeps one fault token per architectural register for a core that hoists loads above branches. A speculative load whose address turns out to be invalid does not trap. It marks its destination register with a token instead. Ordinary register-to-register operations pass tokens from their sources to their destination. A token therefore follows every value that was derived from the failed load.

A check instruction reads one register's token. When the token is set, the block raises a one-cycle redirect that carries the recovery address supplied with the check. The recovery code, which reruns the load without speculation, sits outside this block. So do memory access and the 64-bit data values. Register 0 reads as zero and can never hold a token.

Instructions arrive on a valid/ready issue port, and a transfer happens on a cycle where both are high. The tracker holds ready high except in the cycle in which it drives a redirect. In that cycle it lowers ready, and it ignores whatever is on the port, because the issuing pipeline is being steered away. The redirect output is a plain pulse and has no back-pressure.

Top module: `tok_tracker`

## Requirements
- R1: After synchronous active-high reset, every token is clear, `redir_valid` is low and `iss_ready` is high.
- R2: A speculative load (op code 3) whose `iss_addr_ok` is high leaves its destination token clear.
- R3: A speculative load (op code 3) whose `iss_addr_ok` is low sets its destination token and produces no redirect.
- R4: An ALU operation (op code 1) gives its destination the OR of the tokens of `iss_src_a` and `iss_src_b`.
- R5: A check (op code 4) on a register whose token is set drives `redir_valid` high in the cycle after the check is accepted, with `redir_target` equal to that check's `iss_recover`. The check leaves the token unchanged.
- R6: A check on a register whose token is clear produces no redirect. Op codes 0, 5, 6 and 7 change no token.
- R7: A normal load (op code 2) clears its destination token.
- R8: Register 0 never holds a token. Writes to it are ignored, and a check of it never redirects.
- R9: `redir_valid` is high for exactly one cycle. In that cycle `iss_ready` is low and any instruction offered on the port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_ready | output | 1 | Tracker accepts the instruction this cycle |
| iss_op | input | 3 | Op class: 0 none, 1 ALU, 2 load, 3 speculative load, 4 check |
| iss_dst | input | IDX_W (5) | Destination register |
| iss_src_a | input | IDX_W (5) | First source, also the register a check tests |
| iss_src_b | input | IDX_W (5) | Second source |
| iss_addr_ok | input | 1 | Load address is valid |
| iss_recover | input | ADDR_W (64) | Recovery address carried by a check |
| redir_valid | output | 1 | Redirect pulse |
| redir_target | output | ADDR_W (64) | Recovery address while redirecting |

## Verification
A token written by an accepted instruction is visible to an instruction accepted in the next cycle. A redirect and its target appear one clock edge after the check is accepted. The low `iss_ready` shows up in that same cycle. The bench drives each instruction at a falling edge. At the following falling edge, after exactly one rising edge, it compares `redir_valid`, `redir_target` and `iss_ready` against a token model that it updates only for instructions it predicts are accepted.

// File: rtl/tok_pkg.sv
package tok_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ALU   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_SLOAD = 3'd3,
    OP_CHECK = 3'd4
  } op_e;
endpackage

// File: rtl/tok_file.sv
module tok_file #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_tok,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_a_tok,
  output logic             rd_b_tok,
  output logic [NREG-1:0]  tok_vec
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign tok_vec[g] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)
          tok_vec[g] <= 1'b0;
        else if (wr_en && wr_idx == IDX_W'(g))
          tok_vec[g] <= wr_tok;
      end
    end
  end

  assign rd_a_tok = tok_vec[rd_a_idx];
  assign rd_b_tok = tok_vec[rd_b_idx];
endmodule

// File: rtl/tok_decode.sv
module tok_decode
  import tok_pkg::*;
(
  input  logic [2:0] op,
  input  logic       fire,
  input  logic       addr_ok,
  input  logic       tok_a,
  input  logic       tok_b,
  output logic       wr_en,
  output logic       wr_tok,
  output logic       chk_hit
);
  op_e op_c;
  assign op_c = op_e'(op);

  always_comb begin
    wr_en   = 1'b0;
    wr_tok  = 1'b0;
    chk_hit = 1'b0;
    if (fire) begin
      unique case (op_c)
        OP_ALU:   begin wr_en = 1'b1; wr_tok = tok_a | tok_b; end
        OP_LOAD:  begin wr_en = 1'b1; wr_tok = 1'b0;          end
        OP_SLOAD: begin wr_en = 1'b1; wr_tok = ~addr_ok;      end
        OP_CHECK: chk_hit = tok_a;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tok_redirect.sv
module tok_redirect #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] target_in,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid  <= 1'b0;
      redir_target <= '0;
    end else begin
      redir_valid <= hit;
      if (hit) redir_target <= target_in;
    end
  end
endmodule

// File: rtl/tok_tracker.sv
module tok_tracker #(
  parameter int NREG   = 32,
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [2:0]        iss_op,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic              iss_addr_ok,
  input  logic [ADDR_W-1:0] iss_recover,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  logic            fire;
  logic            tok_a, tok_b;
  logic            wr_en, wr_tok, chk_hit;
  logic [NREG-1:0] tok_vec;

  assign iss_ready = ~redir_valid;
  assign fire      = iss_valid & iss_ready;

  tok_file #(.NREG(NREG), .IDX_W(IDX_W)) file_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(iss_dst), .wr_tok(wr_tok),
    .rd_a_idx(iss_src_a), .rd_b_idx(iss_src_b),
    .rd_a_tok(tok_a), .rd_b_tok(tok_b), .tok_vec(tok_vec)
  );

  tok_decode dec_i (
    .op(iss_op), .fire(fire), .addr_ok(iss_addr_ok),
    .tok_a(tok_a), .tok_b(tok_b),
    .wr_en(wr_en), .wr_tok(wr_tok), .chk_hit(chk_hit)
  );

  tok_redirect #(.ADDR_W(ADDR_W)) redir_i (
    .clk(clk), .rst(rst), .hit(chk_hit), .target_in(iss_recover),
    .redir_valid(redir_valid), .redir_target(redir_target)
  );
endmodule

// File: rtl/tok_tracker_chk.sv
module tok_tracker_chk #(
  parameter int NREG   = 32,
  parameter int IDX_W  = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [2:0]       iss_op,
  input logic [IDX_W-1:0] iss_dst,
  input logic             iss_addr_ok,
  input logic             redir_valid,
  input logic [NREG-1:0]  tok_vec
);
  logic acc;
  assign acc = iss_valid && iss_ready;

  // R9
  redir_once_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);

  // R9
  redir_stall_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !iss_ready);

  // R5
  redir_cause_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> $past(acc && iss_op == 3'd4));

  // R3
  spec_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && iss_op == 3'd3 && !iss_addr_ok && iss_dst != '0)
      |=> tok_vec[$past(iss_dst)]);

  // R7
  plain_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && (iss_op == 3'd2 || (iss_op == 3'd3 && iss_addr_ok)))
      |=> !tok_vec[$past(iss_dst)]);

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    !tok_vec[0]);
endmodule

bind tok_tracker tok_tracker_chk #(.NREG(NREG), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_op(iss_op), .iss_dst(iss_dst), .iss_addr_ok(iss_addr_ok),
  .redir_valid(redir_valid), .tok_vec(tok_vec)
);

// File: tb/tok_tracker_tb.sv
module tok_tracker_tb_top;
  localparam int NREG = 32;
  localparam int ADDR_W = 64;
  localparam int IDX_W = $clog2(NREG);

  logic clk = 0, rst = 1;
  logic iss_valid = 0, iss_ready, iss_addr_ok = 0;
  logic [2:0] iss_op = 0;
  logic [IDX_W-1:0] iss_dst = 0, iss_src_a = 0, iss_src_b = 0;
  logic [ADDR_W-1:0] iss_recover = 0, redir_target;
  logic redir_valid;

  always #2 clk = ~clk;

  tok_tracker #(.NREG(NREG), .ADDR_W(ADDR_W)) dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit tok_m [NREG];
  bit exp_redir = 0;
  logic [ADDR_W-1:0] exp_tgt = 0;
  string pend_tag = "R1";

  task automatic chk(input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp,
                     input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One instruction: check outputs due from the previous one, then drive.
  task automatic step(input bit v, input logic [2:0] op, input int d, input int a,
                      input int b, input bit ok, input logic [ADDR_W-1:0] tgt,
                      input string tag);
    bit acc;
    @(negedge clk);
    chk(redir_valid, exp_redir, pend_tag, "redirect");
    if (exp_redir) chk(redir_target, exp_tgt, pend_tag, "target");
    chk(iss_ready, !exp_redir, exp_redir ? "R9" : pend_tag, "ready");
    iss_valid = v; iss_op = op; iss_dst = IDX_W'(d); iss_src_a = IDX_W'(a);
    iss_src_b = IDX_W'(b); iss_addr_ok = ok; iss_recover = tgt;
    acc = v && !exp_redir;
    exp_redir = acc && op == 3'd4 && tok_m[a];
    if (exp_redir) exp_tgt = tgt;
    if (acc && d != 0) begin
      case (op)
        3'd1: tok_m[d] = tok_m[a] | tok_m[b];
        3'd2: tok_m[d] = 0;
        3'd3: tok_m[d] = !ok;
        default: ;
      endcase
    end
    pend_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    foreach (tok_m[i]) tok_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: clear after reset
    step(1, 3'd4, 0, 5, 0, 0, 64'h10, "R1");
    step(1, 3'd4, 0, 31, 0, 0, 64'h11, "R1");
    // R2
    step(1, 3'd3, 3, 0, 0, 1, 0, "R2");
    step(1, 3'd4, 0, 3, 0, 0, 64'h20, "R2");
    // R3: fault is silent
    step(1, 3'd3, 4, 0, 0, 0, 0, "R3");
    // R5: check fires, target carried
    step(1, 3'd4, 0, 4, 0, 0, 64'hABC, "R5");
    // R9: offered during redirect, ignored (would otherwise clear r4)
    step(1, 3'd2, 4, 0, 0, 1, 0, "R9");
    step(1, 3'd4, 0, 4, 0, 0, 64'hDEF, "R5");
    step(0, 3'd0, 0, 0, 0, 0, 0, "R9");
    // R4: propagation through ALU
    step(1, 3'd1, 6, 0, 4, 0, 0, "R4");
    step(1, 3'd4, 0, 6, 0, 0, 64'h66, "R4");
    step(0, 3'd0, 0, 0, 0, 0, 0, "R9");
    step(1, 3'd1, 7, 0, 3, 0, 0, "R4");
    step(1, 3'd4, 0, 7, 0, 0, 64'h77, "R4");
    // R6: unused op codes change nothing
    step(1, 3'd6, 4, 0, 0, 1, 0, "R6");
    step(1, 3'd4, 0, 4, 0, 0, 64'h44, "R6");
    step(0, 3'd0, 0, 0, 0, 0, 0, "R9");
    // R7: plain load clears
    step(1, 3'd2, 4, 0, 0, 1, 0, "R7");
    step(1, 3'd4, 0, 4, 0, 0, 64'h45, "R7");
    // R8: register 0 stays clear
    step(1, 3'd3, 0, 0, 0, 0, 0, "R8");
    step(1, 3'd4, 0, 0, 0, 0, 64'h1, "R8");
    step(1, 3'd1, 0, 6, 6, 0, 0, "R8");
    step(1, 3'd4, 0, 0, 0, 0, 64'h2, "R8");
    // random mix over registers 0..7
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op > 3'd4 && $urandom_range(0, 3) != 0) op = 3'd4;
      step($urandom_range(0, 9) != 0, op, $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 2) != 0, {$urandom, $urandom},
           op == 3'd4 ? "R5" : "R4");
    end
    step(0, 3'd0, 0, 0, 0, 0, 0, "R6");
    step(0, 3'd0, 0, 0, 0, 0, 0, "R6");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule